// File: doc/BRIEF.md
# Multiplexed external memory bus controller

This controller turns single-word requests from a synchronous CPU-side port into cycles on an 8-bit external bus of the SRAM type. The bus shares one 8-bit lane between the low address byte and the data. An address-latch strobe marks the cycle in which the lane carries the address. The high address byte has a dedicated output, and active-low read and write strobes frame the data phase.

The external address space is split into two sectors by a programmable limit on the high address byte. Each sector has its own two-bit wait setting, so a fast device and a slow device can share the bus. Each wait setting lengthens the strobe and can also add a hold cycle before the next address phase. The CPU can flag that the following operation is also a memory access. When it does, the address strobe is raised again in the closing period of the cycle. An optional bus keeper keeps the last data value on the lane between accesses.

A request is a level on `req` with its address, write flag, write data and next-access flag. The controller accepts it when idle, or in the cycle where `done` is high, which allows back-to-back accesses. A request raised while a cycle is running waits until that cycle ends.

Top module: `xbus_ctrl`

## Requirements
- R1: During and after reset, with no request pending, the address strobe is low, both data strobes are high and `done` is low.
- R2: An access whose high address byte is below `cfg_limit` uses `cfg_wait_lo`, and every other access uses `cfg_wait_hi`. A limit of zero therefore places every address in the upper sector.
- R3: An accepted access lasts 4, 5, 6 or 7 cycles for wait codes 00, 01, 10 and 11, counted from its first cycle. `done` is high for exactly one cycle, the last cycle of the access.
- R4: In cycle 1 the address strobe is high and the lane is driven with the low address byte. `bus_ahi` shows the high address byte in every cycle of the access. The address strobe is low in every other cycle except the one named in R7.
- R5: For a write, `bus_wr_n` is low from cycle 2 through cycle 3+e, where e is 0, 1, 2 and 2 for codes 00, 01, 10 and 11. The lane is driven with the write data from cycle 2 to the end of the access.
- R6: For a read, `bus_rd_n` is low over the same cycles as in R5 and the lane is released while it is low. `rdata` takes the lane value present in the last cycle with the read strobe low, which is the edge where the strobe rises.
- R7: In cycle 4+e the address strobe equals the next-access flag given with the request. For code 11 a further hold cycle follows with the address strobe low.
- R8: With `cfg_keep` set, the lane is driven outside the address and strobe phases with the last data transferred, either write data or captured read data. With `cfg_keep` clear, the lane is released there.
- R9: A request held high during an access is accepted at the end of that access's `done` cycle, so its cycle 1 follows at once. Request inputs changed during an access do not alter the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request level |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| req_next_ram | input | 1 | Following operation is also a memory access |
| done | output | 1 | One-cycle pulse in the last cycle of an access |
| rdata | output | 8 | Captured read data |
| cfg_limit | input | 8 | Sector limit on the high address byte |
| cfg_wait_lo | input | 2 | Wait code for the lower sector |
| cfg_wait_hi | input | 2 | Wait code for the upper sector |
| cfg_keep | input | 1 | Bus keeper enable |
| bus_ale | output | 1 | Address latch strobe, active high |
| bus_ahi | output | 8 | High address byte |
| bus_lane_o | output | 8 | Lane output value |
| bus_lane_oe | output | 1 | Lane output enable |
| bus_lane_i | input | 8 | Lane input value |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |

## Verification
The `done` pulse that ends one access can land in the same cycle as the acceptance of the next request. With the next-access flag set, it also coincides with the closing address strobe. The bench provokes this by raising the next request in cycle 2 of a running access and changing its address, direction and data. Each cycle is then checked against two expectations: the current access must finish with its own latched values and wait length, and the following cycle must be cycle 1 of the new access, with the strobe and lane showing the new address.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_STRB,
      ST_LAST,
      ST_HOLD
   } xbus_state_t;

   function automatic logic [1:0] wait_extra(input logic [1:0] code);
      return (code == 2'd0) ? 2'd0 : (code == 2'd1) ? 2'd1 : 2'd2;
   endfunction

   function automatic logic wait_hold(input logic [1:0] code);
      return code == 2'd3;
   endfunction

endpackage

// File: rtl/xbus_sector.sv
module xbus_sector #(
   parameter int HW = 8,
   parameter int WW = 2
) (
   input  logic [HW-1:0] addr_hi,
   input  logic [HW-1:0] limit,
   input  logic [WW-1:0] wait_lo,
   input  logic [WW-1:0] wait_hi,
   output logic [1:0]    extra,
   output logic          hold
);
   import xbus_pkg::*;

   logic          in_lower;
   logic [WW-1:0] code;

   assign in_lower = addr_hi < limit;
   assign code     = in_lower ? wait_lo : wait_hi;

   generate
      if (WW == 2) begin : g_two_bit
         assign extra = wait_extra(code);
         assign hold  = wait_hold(code);
      end else begin : g_bad_width
         $error("xbus_sector: wait field must be two bits wide");
      end
   endgenerate

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
   import xbus_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req,
   input  logic [1:0]  extra_in,
   input  logic        hold_in,
   output xbus_state_t state,
   output logic        accept,
   output logic        capture,
   output logic        done
);
   xbus_state_t st_q;
   logic [1:0]  cnt_q;
   logic        hold_q;

   assign state   = st_q;
   assign done    = (st_q == ST_LAST && !hold_q) || (st_q == ST_HOLD);
   assign accept  = req && (st_q == ST_IDLE || done);
   assign capture = (st_q == ST_STRB) && (cnt_q == 2'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cnt_q  <= 2'd0;
         hold_q <= 1'b0;
      end else begin
         if (accept) begin
            cnt_q  <= extra_in + 2'd1;
            hold_q <= hold_in;
         end else if (st_q == ST_STRB && cnt_q != 2'd0) begin
            cnt_q <= cnt_q - 2'd1;
         end
         case (st_q)
            ST_ADDR: st_q <= ST_STRB;
            ST_STRB: if (cnt_q == 2'd0) st_q <= ST_LAST;
            ST_LAST: begin
               if (hold_q)      st_q <= ST_HOLD;
               else if (accept) st_q <= ST_ADDR;
               else             st_q <= ST_IDLE;
            end
            default: st_q <= accept ? ST_ADDR : ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/xbus_lane.sv
module xbus_lane
   import xbus_pkg::*;
#(
   parameter int DW      = 8,
   parameter bit KEEP_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  xbus_state_t   state,
   input  logic          we,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] addr_lo,
   input  logic          capture,
   input  logic          keep_en,
   input  logic [DW-1:0] lane_i,
   output logic [DW-1:0] lane_o,
   output logic          lane_oe,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] rd_q;
   logic [DW-1:0] held;
   logic          idle_oe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              rd_q <= '0;
      else if (capture && !we) rd_q <= lane_i;
   end
   assign rdata = rd_q;

   generate
      if (KEEP_EN) begin : g_keeper
         logic [DW-1:0] keep_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        keep_q <= '0;
            else if (state == ST_ADDR && we)   keep_q <= wdata;
            else if (capture && !we)           keep_q <= lane_i;
         end
         assign held    = keep_q;
         assign idle_oe = keep_en;
      end else begin : g_no_keeper
         assign held    = wdata;
         assign idle_oe = 1'b0;
      end
   endgenerate

   always_comb begin
      lane_o  = held;
      lane_oe = idle_oe;
      if (state == ST_ADDR) begin
         lane_o  = addr_lo;
         lane_oe = 1'b1;
      end else if (we && state != ST_IDLE) begin
         lane_oe = 1'b1;
      end else if (state == ST_STRB) begin
         lane_oe = 1'b0;
      end
   end

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
   import xbus_pkg::*;
#(
   parameter int AW      = 16,
   parameter int DW      = 8,
   parameter bit KEEP_EN = 1'b1,
   localparam int HW     = AW - DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic          req_we,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic          req_next_ram,
   output logic          done,
   output logic [DW-1:0] rdata,
   input  logic [HW-1:0] cfg_limit,
   input  logic [1:0]    cfg_wait_lo,
   input  logic [1:0]    cfg_wait_hi,
   input  logic          cfg_keep,
   output logic          bus_ale,
   output logic [HW-1:0] bus_ahi,
   output logic [DW-1:0] bus_lane_o,
   output logic          bus_lane_oe,
   input  logic [DW-1:0] bus_lane_i,
   output logic          bus_rd_n,
   output logic          bus_wr_n
);
   generate
      if (DW < 1 || AW <= DW) begin : g_bad_geom
         $error("xbus_ctrl: address must be wider than the data lane");
      end
   endgenerate

   xbus_state_t   state;
   logic          accept, capture;
   logic [1:0]    extra;
   logic          hold;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wd_q;
   logic          we_q, nr_q;

   xbus_sector #(.HW(HW), .WW(2)) u_sector (
      .addr_hi (req_addr[AW-1:DW]),
      .limit   (cfg_limit),
      .wait_lo (cfg_wait_lo),
      .wait_hi (cfg_wait_hi),
      .extra   (extra),
      .hold    (hold)
   );

   xbus_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .extra_in (extra),
      .hold_in  (hold),
      .state    (state),
      .accept   (accept),
      .capture  (capture),
      .done     (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         wd_q   <= '0;
         we_q   <= 1'b0;
         nr_q   <= 1'b0;
      end else if (accept) begin
         addr_q <= req_addr;
         wd_q   <= req_wdata;
         we_q   <= req_we;
         nr_q   <= req_next_ram;
      end
   end

   assign bus_ahi  = addr_q[AW-1:DW];
   assign bus_ale  = (state == ST_ADDR) || (state == ST_LAST && nr_q);
   assign bus_rd_n = !(state == ST_STRB && !we_q);
   assign bus_wr_n = !(state == ST_STRB && we_q);

   xbus_lane #(.DW(DW), .KEEP_EN(KEEP_EN)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .state   (state),
      .we      (we_q),
      .wdata   (wd_q),
      .addr_lo (addr_q[DW-1:0]),
      .capture (capture),
      .keep_en (cfg_keep),
      .lane_i  (bus_lane_i),
      .lane_o  (bus_lane_o),
      .lane_oe (bus_lane_oe),
      .rdata   (rdata)
   );

endmodule

// File: rtl/xbus_chk.sv
module xbus_chk #(
   parameter int HW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req,
   input logic          done,
   input logic          bus_ale,
   input logic          bus_rd_n,
   input logic          bus_wr_n,
   input logic          bus_lane_oe,
   input logic [HW-1:0] bus_ahi
);
   assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd_n || bus_wr_n);

   assert_wr_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr_n |-> bus_lane_oe);

   assert_rd_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_n |-> !bus_lane_oe);

   assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_chain_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && req) |=> bus_ale);

   assert_ale_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ale |-> (bus_rd_n && bus_wr_n));

   assert_strobe_after_ale_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bus_rd_n) || $fell(bus_wr_n)) |-> $past(bus_ale));

   assert_ahi_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd_n || !bus_wr_n) |-> $stable(bus_ahi));

endmodule

bind xbus_ctrl xbus_chk #(.HW(HW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req         (req),
   .done        (done),
   .bus_ale     (bus_ale),
   .bus_rd_n    (bus_rd_n),
   .bus_wr_n    (bus_wr_n),
   .bus_lane_oe (bus_lane_oe),
   .bus_ahi     (bus_ahi)
);

// File: tb/sim_xbus_ctrl.sv
`timescale 1ns/1ps
module sim_xbus_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, req_we = 1'b0, req_next_ram = 1'b0;
   logic [15:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        done;
   logic [7:0]  rdata;
   logic [7:0]  cfg_limit = 8'h80;
   logic [1:0]  cfg_wait_lo = 2'd0, cfg_wait_hi = 2'd0;
   logic        cfg_keep = 1'b0;
   logic        bus_ale, bus_lane_oe, bus_rd_n, bus_wr_n;
   logic [7:0]  bus_ahi, bus_lane_o;
   logic [7:0]  bus_lane_i = '0;

   int checks = 0, failures = 0;
   logic [7:0] last_data = 8'h00;

   logic        nx_we, nx_nr;
   logic [15:0] nx_addr;
   logic [7:0]  nx_wd;

   always #4 clk = ~clk;

   xbus_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_next_ram(req_next_ram), .done(done), .rdata(rdata),
      .cfg_limit(cfg_limit), .cfg_wait_lo(cfg_wait_lo), .cfg_wait_hi(cfg_wait_hi),
      .cfg_keep(cfg_keep), .bus_ale(bus_ale), .bus_ahi(bus_ahi), .bus_lane_o(bus_lane_o),
      .bus_lane_oe(bus_lane_oe), .bus_lane_i(bus_lane_i), .bus_rd_n(bus_rd_n),
      .bus_wr_n(bus_wr_n)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
      end
   endtask

   task automatic present(input logic we, input logic [15:0] addr,
                          input logic [7:0] wd, input logic nr);
      req = 1'b1; req_we = we; req_addr = addr; req_wdata = wd; req_next_ram = nr;
   endtask

   // Runs one access that is accepted at the next rising edge.
   task automatic do_acc(input logic we, input logic [15:0] addr, input logic [7:0] wd,
                         input logic nr, input logic [7:0] rv,
                         input bit chain, input bit follow);
      logic [1:0] code;
      int ex, hd, n, lastst, t4;
      code   = (addr[15:8] < cfg_limit) ? cfg_wait_lo : cfg_wait_hi;
      ex     = (code == 2'd0) ? 0 : (code == 2'd1) ? 1 : 2;
      hd     = (code == 2'd3) ? 1 : 0;
      n      = 4 + ex + hd;
      lastst = 3 + ex;
      t4     = 4 + ex;
      bus_lane_i = ~rv;
      for (int k = 1; k <= n; k++) begin
         logic exp_oe;
         @(negedge clk);
         if (k == 1) req = 1'b0;
         if (chain && k == 2) present(nx_we, nx_addr, nx_wd, nx_nr);
         bus_lane_i = (k == lastst) ? rv : ~rv;
         chk(chain ? "R9" : "R4", "ahi", bus_ahi, addr[15:8]);
         if (k == 1)       chk(follow ? "R9" : "R4", "ale T1", bus_ale, 1'b1);
         else if (k == t4) chk("R7", "ale T4", bus_ale, nr);
         else              chk("R7", "ale low", bus_ale, 1'b0);
         chk("R5", "wr_n", bus_wr_n, !(we && k >= 2 && k <= lastst));
         chk("R6", "rd_n", bus_rd_n, !(!we && k >= 2 && k <= lastst));
         chk("R2/R3", "done", done, k == n);
         if (k == 1)            exp_oe = 1'b1;
         else if (we)           exp_oe = 1'b1;
         else if (k <= lastst)  exp_oe = 1'b0;
         else                   exp_oe = cfg_keep;
         chk((k > lastst && !we) ? "R8" : "R6", "lane_oe", bus_lane_oe, exp_oe);
         if (exp_oe) begin
            if (k == 1)  chk("R4", "lane addr", bus_lane_o, addr[7:0]);
            else if (we) chk("R5", "lane wdata", bus_lane_o, wd);
            else         chk("R8", "lane keep rd", bus_lane_o, rv);
         end
         if (k == n && !we) chk("R6", "rdata", rdata, rv);
      end
      last_data = we ? wd : rv;
   endtask

   task automatic idle_chk();
      @(negedge clk);
      chk("R1", "idle done", done, 1'b0);
      chk("R1", "idle ale", bus_ale, 1'b0);
      chk("R1", "idle strobes", {bus_rd_n, bus_wr_n}, 2'b11);
      chk("R8", "idle oe", bus_lane_oe, cfg_keep);
      if (cfg_keep) chk("R8", "idle lane", bus_lane_o, last_data);
   endtask

   task automatic single(input logic we, input logic [15:0] addr, input logic [7:0] wd,
                         input logic nr, input logic [7:0] rv);
      @(negedge clk);
      present(we, addr, wd, nr);
      do_acc(we, addr, wd, nr, rv, 1'b0, 1'b0);
      idle_chk();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL R3 watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", "reset ale", bus_ale, 1'b0);
      chk("R1", "reset strobes", {bus_rd_n, bus_wr_n}, 2'b11);
      chk("R1", "reset done", done, 1'b0);
      chk("R1", "reset oe", bus_lane_oe, 1'b0);
      rst_n = 1'b1;
      idle_chk();

      // Sweep both sectors over all wait codes, both directions, keeper on/off
      for (int kp = 0; kp < 2; kp++) begin
         for (int wl = 0; wl < 4; wl++) begin
            for (int wh = 0; wh < 4; wh++) begin
               logic [7:0] s;
               cfg_keep = kp[0]; cfg_wait_lo = wl[1:0]; cfg_wait_hi = wh[1:0];
               s = 8'(kp * 16 + wl * 4 + wh);
               single(1'b1, {8'h7F, s},        s ^ 8'h5A, s[0],  8'h00);
               single(1'b0, {8'h12, s ^ 8'hFF}, 8'h00,    !s[0], s ^ 8'hC3);
               single(1'b1, {8'h80, s},        s ^ 8'hA5, !s[0], 8'h00);
               single(1'b0, {8'hFF, s},        8'h00,    s[0],  s ^ 8'h3C);
            end
         end
      end

      // R2: limit of zero puts the bottom of the space in the upper sector
      cfg_limit = 8'h00; cfg_wait_lo = 2'd0; cfg_wait_hi = 2'd3; cfg_keep = 1'b1;
      single(1'b0, 16'h0000, 8'h00, 1'b0, 8'h96);
      single(1'b1, 16'h00FF, 8'h69, 1'b1, 8'h00);

      // R9: requests raised mid-access, chained across done cycles
      cfg_limit = 8'h40; cfg_wait_lo = 2'd1; cfg_wait_hi = 2'd3;
      @(negedge clk);
      present(1'b1, 16'h3F11, 8'hE7, 1'b1);
      nx_we = 1'b0; nx_addr = 16'h4022; nx_wd = 8'h00; nx_nr = 1'b1;
      do_acc(1'b1, 16'h3F11, 8'hE7, 1'b1, 8'h00, 1'b1, 1'b0);
      nx_we = 1'b1; nx_addr = 16'h0133; nx_wd = 8'h4B; nx_nr = 1'b0;
      do_acc(1'b0, 16'h4022, 8'h00, 1'b1, 8'hD2, 1'b1, 1'b1);
      do_acc(1'b1, 16'h0133, 8'h4B, 1'b0, 8'h00, 1'b0, 1'b1);
      idle_chk();

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule